// File: doc/BRIEF.md
# Integer Arithmetic Execute Unit (64/32-bit)

This unit performs the arithmetic step of a 64-bit register-machine processor. Each request supplies a 4-bit operation code and a mode flag that chooses 64-bit or 32-bit operation. It also supplies a source-select bit, a 16-bit modifier field, the current destination value, and either a register source value or a 32-bit immediate. The unit answers with the new destination value. A request is accepted with a `start` pulse while the unit is idle. The answer appears with a one-cycle `done` pulse, and `result` holds its value until the next answer.

Most operations finish in the cycle after acceptance. Division and remainder with a non-zero divisor run on a bit-serial divider. The unit stays `busy` while the divider runs. The unit also handles sign-extending moves, masked shifts, negation and byte-order conversion. It flags undefined encodings instead of producing a result for them.

Top module: `ialu_exec`

## Requirements
- R1: While `busy` is low, a `start` is accepted. A non-division operation raises `done` for one cycle after the accepting edge. A `start` seen while `busy` is high is ignored. While `busy` is high, `done` stays low and `result` holds its value.
- R2: The operation codes are add 0, sub 1, mul 2, div 3, or 4, and 5, shift-left 6, logical shift-right 7, negate 8, remainder 9, xor 0xa, move 0xb, arithmetic shift-right 0xc and byte-order 0xd. Add, sub and mul keep the low bits of the result, so they wrap on overflow.
- R3: With `wide`=0, each operation uses the low 32 bits of its operands and `result[63:32]` is zero. The byte-order operation (code 0xd) is the only exception.
- R4: With `use_reg`=0 the source is `imm` sign-extended to 64 bits. In 64-bit mode this sign-extended value is also the divisor for unsigned division and remainder.
- R5: A zero divisor gives a result in the cycle after acceptance. For division the result is 0. For remainder in 64-bit mode the result is `dst_in`. For remainder in 32-bit mode the result is the low 32 bits of `dst_in`, with the upper half zero.
- R6: For codes 3 and 9, `offset`=0 selects unsigned operation and `offset`=1 selects signed operation. Signed division truncates toward zero, and the sign of the remainder follows the dividend (-13 rem 3 = -1).
- R7: Division or remainder with a non-zero divisor makes `busy` high. `done` then rises exactly 65 clock edges after the accepting edge (DATA_W+1).
- R8: The shift amount is the source masked with 63 in 64-bit mode and with 31 in 32-bit mode. The arithmetic shift fills the vacated bits with the sign bit of the operand width.
- R9: Negate (code 8) with `use_reg`=0 returns the two's complement negation of `dst_in`.
- R10: A move (code 0xb) with `offset` 8, 16 or 32 and `use_reg`=1 sign-extends that many low bits of `src_in`. In 32-bit mode the extension stops at bit 31 and only offsets 8 and 16 are allowed.
- R11: Byte-order in 64-bit mode with `use_reg`=0 always reverses the bytes of the low 16, 32 or 64 bits of `dst_in`, with the width taken from `imm`. The bits above that width are zeroed.
- R12: Byte-order in 32-bit mode converts to little-endian (`use_reg`=0) or big-endian (`use_reg`=1). When the target order equals the HOST_BIG order, the value passes through truncated to the width with the upper bits zeroed. Otherwise the bytes are reversed. The width can be 16, 32 or 64.
- R13: Each of the following is undefined and raises `illegal` with `done`, with `result` equal to `dst_in`:
  - codes 0xe and 0xf;
  - a non-zero `offset` on any code other than 3, 9 and 0xb, or an `offset` above 1 on codes 3 and 9;
  - negate with `use_reg`=1;
  - a move offset other than 0, 8, 16 or 32, a non-zero move offset with `use_reg`=0, or offset 32 in 32-bit mode;
  - a byte-order width other than 16, 32 or 64, or byte-order in 64-bit mode with `use_reg`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| op | input | 4 | Operation code |
| wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| use_reg | input | 1 | 1 = register source, 0 = immediate (byte-order: target order) |
| offset | input | 16 | Modifier field (signed select, extension width) |
| imm | input | 32 | Immediate value (byte-order: width) |
| dst_in | input | 64 | Current destination value |
| src_in | input | 64 | Register source value |
| busy | output | 1 | Divider running |
| done | output | 1 | One-cycle answer strobe |
| illegal | output | 1 | Undefined encoding, valid with done |
| result | output | 64 | New destination value |

## Verification
The operand patterns are chosen so that each mistake gives a visibly wrong value:
- Carries out of bit 63 and bit 31 separate correct wrapping and upper-half zeroing from versions that keep or leak the carry.
- Negative immediates and dividends separate sign extension from zero extension, and truncating division from floored division.
- Shift counts above the mask separate masked shifts from unmasked ones.
- A divisor of zero is checked for both latency and value, because it must skip the divider.
- For byte-order, a value with all bytes distinct shows, at every width and in both modes, whether a swap or a pass-through took place and whether truncation happened.
- Each undefined encoding is applied with a known destination, which shows that no partial result escapes.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_SUB  = 4'h1;
  localparam logic [3:0] OP_MUL  = 4'h2;
  localparam logic [3:0] OP_DIV  = 4'h3;
  localparam logic [3:0] OP_OR   = 4'h4;
  localparam logic [3:0] OP_AND  = 4'h5;
  localparam logic [3:0] OP_LSH  = 4'h6;
  localparam logic [3:0] OP_RSH  = 4'h7;
  localparam logic [3:0] OP_NEG  = 4'h8;
  localparam logic [3:0] OP_MOD  = 4'h9;
  localparam logic [3:0] OP_XOR  = 4'ha;
  localparam logic [3:0] OP_MOV  = 4'hb;
  localparam logic [3:0] OP_ARSH = 4'hc;
  localparam logic [3:0] OP_END  = 4'hd;
endpackage

// File: rtl/ialu_bswap.sv
// Byte reversal of the low 16, 32 and full width of a value, upper bytes zeroed.
module ialu_bswap #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] val,
  output logic [DATA_W-1:0] sw16,
  output logic [DATA_W-1:0] sw32,
  output logic [DATA_W-1:0] swfull
);
  localparam int NB = DATA_W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign swfull[b*8 +: 8] = val[(NB-1-b)*8 +: 8];
    if (b < 4) begin : g_w32
      assign sw32[b*8 +: 8] = val[(3-b)*8 +: 8];
    end else begin : g_z32
      assign sw32[b*8 +: 8] = 8'h00;
    end
    if (b < 2) begin : g_w16
      assign sw16[b*8 +: 8] = val[(1-b)*8 +: 8];
    end else begin : g_z16
      assign sw16[b*8 +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/ialu_divu.sv
// Radix-2 restoring unsigned divider, one quotient bit per clock.
module ialu_divu #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         fin
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  quo_r, rem_r, den_r;
  logic [CW-1:0] cnt_r;
  logic          run_r, fin_r;
  logic [W:0]    shifted, diff;

  assign shifted = {rem_r, quo_r[W-1]};
  assign diff    = shifted - {1'b0, den_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_r <= '0;
      rem_r <= '0;
      den_r <= '0;
      cnt_r <= '0;
      run_r <= 1'b0;
      fin_r <= 1'b0;
    end else begin
      fin_r <= 1'b0;
      if (go) begin
        quo_r <= num;
        rem_r <= '0;
        den_r <= den;
        cnt_r <= '0;
        run_r <= 1'b1;
      end else if (run_r) begin
        if (!diff[W]) begin
          rem_r <= diff[W-1:0];
          quo_r <= {quo_r[W-2:0], 1'b1};
        end else begin
          rem_r <= shifted[W-1:0];
          quo_r <= {quo_r[W-2:0], 1'b0};
        end
        cnt_r <= cnt_r + 1'b1;
        if (cnt_r == CW'(W-1)) begin
          run_r <= 1'b0;
          fin_r <= 1'b1;
        end
      end
    end
  end

  assign quo = quo_r;
  assign rem = rem_r;
  assign fin = fin_r;
endmodule

// File: rtl/ialu_fast.sv
// Single-cycle operations, legality decode and divider operand preparation.
module ialu_fast
  import ialu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter bit HOST_BIG = 1'b0
) (
  input  logic [3:0]          op,
  input  logic                wide,
  input  logic                use_reg,
  input  logic [15:0]         offset,
  input  logic [DATA_W/2-1:0] imm,
  input  logic [DATA_W-1:0]   dst,
  input  logic [DATA_W-1:0]   src,
  output logic [DATA_W-1:0]   res,
  output logic                ill,
  output logic                div_job,
  output logic [DATA_W-1:0]   div_num,
  output logic [DATA_W-1:0]   div_den,
  output logic                q_neg,
  output logic                r_neg
);
  localparam int HW   = DATA_W / 2;
  localparam int SH_W = $clog2(DATA_W);
  localparam int SH_N = $clog2(HW);

  logic [DATA_W-1:0] imm_x, opnd;
  logic [HW-1:0]     a_lo, b_lo;
  logic [SH_W-1:0]   sh_w;
  logic [SH_N-1:0]   sh_n;
  logic              den_zero;
  logic [DATA_W-1:0] sw16, sw32, swfull;

  assign imm_x    = {{HW{imm[HW-1]}}, imm};
  assign opnd     = use_reg ? src : imm_x;
  assign a_lo     = dst[HW-1:0];
  assign b_lo     = opnd[HW-1:0];
  assign sh_w     = opnd[SH_W-1:0];
  assign sh_n     = opnd[SH_N-1:0];
  assign den_zero = wide ? (opnd == '0) : (b_lo == '0);

  ialu_bswap #(.DATA_W(DATA_W)) u_swap (
    .val(dst), .sw16(sw16), .sw32(sw32), .swfull(swfull)
  );

  logic [DATA_W-1:0] r_w;
  logic [HW-1:0]     r_n;
  logic [DATA_W-1:0] r_end, r_trunc, r_sw;
  logic              end_sel, end_swap, need_div;

  assign end_swap = wide | (use_reg ^ HOST_BIG);

  always_comb begin
    r_w      = '0;
    r_n      = '0;
    ill      = 1'b0;
    end_sel  = 1'b0;
    need_div = 1'b0;
    r_trunc  = '0;
    r_sw     = '0;
    case (op)
      OP_ADD:  begin r_w = dst + opnd; r_n = a_lo + b_lo; ill = |offset; end
      OP_SUB:  begin r_w = dst - opnd; r_n = a_lo - b_lo; ill = |offset; end
      OP_MUL:  begin r_w = dst * opnd; r_n = a_lo * b_lo; ill = |offset; end
      OP_OR:   begin r_w = dst | opnd; r_n = a_lo | b_lo; ill = |offset; end
      OP_AND:  begin r_w = dst & opnd; r_n = a_lo & b_lo; ill = |offset; end
      OP_XOR:  begin r_w = dst ^ opnd; r_n = a_lo ^ b_lo; ill = |offset; end
      OP_LSH:  begin r_w = dst << sh_w; r_n = a_lo << sh_n; ill = |offset; end
      OP_RSH:  begin r_w = dst >> sh_w; r_n = a_lo >> sh_n; ill = |offset; end
      OP_ARSH: begin
        r_w = DATA_W'($signed(dst) >>> sh_w);
        r_n = HW'($signed(a_lo) >>> sh_n);
        ill = |offset;
      end
      OP_NEG:  begin r_w = -dst; r_n = -a_lo; ill = use_reg | (|offset); end
      OP_DIV, OP_MOD: begin
        ill = (offset > 16'd1);
        if (den_zero) begin
          r_w = (op == OP_MOD) ? dst  : '0;
          r_n = (op == OP_MOD) ? a_lo : '0;
        end else begin
          need_div = 1'b1;
        end
      end
      OP_MOV: begin
        case (offset)
          16'd0: begin r_w = opnd; r_n = b_lo; end
          16'd8: begin
            r_w = {{(DATA_W-8){src[7]}}, src[7:0]};
            r_n = {{(HW-8){src[7]}}, src[7:0]};
            ill = !use_reg;
          end
          16'd16: begin
            r_w = {{(DATA_W-16){src[15]}}, src[15:0]};
            r_n = {{(HW-16){src[15]}}, src[15:0]};
            ill = !use_reg;
          end
          16'd32: begin
            r_w = {{HW{src[HW-1]}}, src[HW-1:0]};
            ill = !use_reg || !wide;
          end
          default: ill = 1'b1;
        endcase
      end
      OP_END: begin
        end_sel = 1'b1;
        if (imm == HW'(16)) begin
          r_sw = sw16; r_trunc = {{(DATA_W-16){1'b0}}, dst[15:0]};
        end else if (imm == HW'(32)) begin
          r_sw = sw32; r_trunc = {{HW{1'b0}}, dst[HW-1:0]};
        end else if (imm == HW'(64)) begin
          r_sw = swfull; r_trunc = dst;
        end else begin
          ill = 1'b1;
        end
        if ((|offset) || (wide && use_reg)) ill = 1'b1;
      end
      default: ill = 1'b1;
    endcase
  end

  assign r_end   = end_swap ? r_sw : r_trunc;
  assign div_job = need_div & ~ill;

  always_comb begin
    if (ill)          res = dst;
    else if (end_sel) res = r_end;
    else if (wide)    res = r_w;
    else              res = {{HW{1'b0}}, r_n};
  end

  // Divider operands as magnitudes, with the sign fix-up noted for later.
  logic [DATA_W-1:0] nn, dd;
  logic              sgn;
  assign sgn = offset[0];

  always_comb begin
    if (wide) begin
      nn = dst;
      dd = opnd;
    end else if (sgn) begin
      nn = {{HW{a_lo[HW-1]}}, a_lo};
      dd = {{HW{b_lo[HW-1]}}, b_lo};
    end else begin
      nn = {{HW{1'b0}}, a_lo};
      dd = {{HW{1'b0}}, b_lo};
    end
  end

  assign q_neg   = sgn & (nn[DATA_W-1] ^ dd[DATA_W-1]);
  assign r_neg   = sgn & nn[DATA_W-1];
  assign div_num = (sgn & nn[DATA_W-1]) ? -nn : nn;
  assign div_den = (sgn & dd[DATA_W-1]) ? -dd : dd;
endmodule

// File: rtl/ialu_exec.sv
module ialu_exec
  import ialu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter bit HOST_BIG = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [3:0]          op,
  input  logic                wide,
  input  logic                use_reg,
  input  logic [15:0]         offset,
  input  logic [DATA_W/2-1:0] imm,
  input  logic [DATA_W-1:0]   dst_in,
  input  logic [DATA_W-1:0]   src_in,
  output logic                busy,
  output logic                done,
  output logic                illegal,
  output logic [DATA_W-1:0]   result
);
  localparam int HW = DATA_W / 2;

  logic [DATA_W-1:0] f_res, f_num, f_den;
  logic              f_ill, f_div_job, f_qneg, f_rneg;

  ialu_fast #(.DATA_W(DATA_W), .HOST_BIG(HOST_BIG)) u_fast (
    .op(op), .wide(wide), .use_reg(use_reg), .offset(offset), .imm(imm),
    .dst(dst_in), .src(src_in), .res(f_res), .ill(f_ill),
    .div_job(f_div_job), .div_num(f_num), .div_den(f_den),
    .q_neg(f_qneg), .r_neg(f_rneg)
  );

  logic              busy_q, done_q, ill_q;
  logic [DATA_W-1:0] res_q;
  logic [3:0]        job_op;
  logic              job_wide, job_qneg, job_rneg, job_mod;

  // Named events for the checks below.
  logic              accept, div_go, div_fin;
  logic [DATA_W-1:0] d_quo, d_rem;

  assign accept = start & ~busy_q;
  assign div_go = accept & f_div_job;

  ialu_divu #(.W(DATA_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(f_num), .den(f_den),
    .quo(d_quo), .rem(d_rem), .fin(div_fin)
  );

  logic [DATA_W-1:0] q_fix, r_fix, pick, fix_res;
  assign q_fix   = job_qneg ? -d_quo : d_quo;
  assign r_fix   = job_rneg ? -d_rem : d_rem;
  assign pick    = job_mod ? r_fix : q_fix;
  assign fix_res = job_wide ? pick : {{HW{1'b0}}, pick[HW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      ill_q    <= 1'b0;
      res_q    <= '0;
      job_op   <= '0;
      job_wide <= 1'b0;
      job_qneg <= 1'b0;
      job_rneg <= 1'b0;
      job_mod  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        job_op   <= op;
        job_wide <= wide;
        if (f_div_job) begin
          busy_q   <= 1'b1;
          job_qneg <= f_qneg;
          job_rneg <= f_rneg;
          job_mod  <= (op == OP_MOD);
        end else begin
          done_q <= 1'b1;
          res_q  <= f_res;
          ill_q  <= f_ill;
        end
      end else if (busy_q && div_fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        res_q  <= fix_res;
        ill_q  <= 1'b0;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign illegal = ill_q;
  assign result  = res_q;

  // R1: no answer and no result change while the divider is still working
  a_r1_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !div_fin |=> !done_q);
  a_r1_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !div_fin |=> $stable(res_q));
  // R7: the divider only finishes while a division job is open
  a_r7_fin_in_job: assert property (@(posedge clk) disable iff (!rst_n)
    div_fin |-> busy_q);
  // R3: 32-bit answers carry a zero upper half (byte-order excepted)
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !ill_q && !job_wide && (job_op != OP_END)
      |-> (res_q[DATA_W-1:HW] == '0));
  // R13: an undefined encoding returns the destination it was given
  a_r13_keep_dst: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && ill_q |-> (res_q == $past(dst_in)));
endmodule

// File: tb/sim_ialu_exec.sv
`timescale 1ns/1ps
module sim_ialu_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic        wide = 1'b0;
  logic        use_reg = 1'b0;
  logic [15:0] offset = '0;
  logic [31:0] imm = '0;
  logic [63:0] dst_in = '0;
  logic [63:0] src_in = '0;
  logic        busy, done, illegal;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [63:0] r_res;
  logic        r_ill;
  int          r_cyc;

  always #2.5 clk = ~clk;

  ialu_exec u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
    .use_reg(use_reg), .offset(offset), .imm(imm), .dst_in(dst_in),
    .src_in(src_in), .busy(busy), .done(done), .illegal(illegal),
    .result(result)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic w, input logic r,
                     input logic [15:0] off, input logic [31:0] im,
                     input logic [63:0] d, input logic [63:0] s);
    @(negedge clk);
    op = o; wide = w; use_reg = r; offset = off; imm = im; dst_in = d; src_in = s;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    r_cyc = 0;
    while (!done && r_cyc < 200) begin
      @(posedge clk); #1;
      r_cyc++;
    end
    r_res = result;
    r_ill = illegal;
  endtask

  task automatic t_reset;
    chk("R1 reset done", {63'd0, done}, 64'd0);
    chk("R1 reset busy", {63'd0, busy}, 64'd0);
    chk("R1 reset result", result, 64'd0);
  endtask

  task automatic t_basic;
    run(4'h0, 1, 1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
    chk("R2 add wrap", r_res, 64'd1);
    chk("R1 one-cycle latency", 64'(r_cyc), 64'd0);
    chk("R2 legal flag", {63'd0, r_ill}, 64'd0);
    run(4'h1, 1, 0, 0, 32'd7, 64'd5, 64'd0);
    chk("R4 sub negative imm", r_res, 64'hFFFF_FFFF_FFFF_FFFE);
    run(4'h2, 1, 1, 0, 0, 64'h1_0000_0000, 64'h1_0000_0001);
    chk("R2 mul wrap", r_res, 64'h0000_0001_0000_0000);
    run(4'h4, 1, 1, 0, 0, 64'hF0F0, 64'h0F0F_0000);
    chk("R2 or", r_res, 64'h0F0F_F0F0);
    run(4'h5, 1, 1, 0, 0, 64'hFF00_FF00, 64'h0FF0_0FF0);
    chk("R2 and", r_res, 64'h0F00_0F00);
    run(4'ha, 1, 0, 0, 32'hFFFF_FFFF, 64'h1234, 64'd0);
    chk("R4 xor sign-extended imm", r_res, ~64'h1234);
    run(4'hb, 1, 0, 0, 32'hFFFF_FFFF, 64'd0, 64'd0);
    chk("R4 mov imm", r_res, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_narrow;
    run(4'h0, 0, 1, 0, 0, 64'hAAAA_BBBB_FFFF_FFFF, 64'h1234_0000_0000_0002);
    chk("R3 add 32 wrap", r_res, 64'd1);
    run(4'hb, 0, 0, 0, 32'hFFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'd0);
    chk("R3 mov 32 zero upper", r_res, 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_zero;
    run(4'h3, 1, 1, 0, 0, 64'd99, 64'd0);
    chk("R5 div by zero", r_res, 64'd0);
    chk("R5 zero divisor latency", 64'(r_cyc), 64'd0);
    run(4'h9, 1, 1, 0, 0, 64'h1234_5678_9ABC_DEF0, 64'd0);
    chk("R5 mod zero 64", r_res, 64'h1234_5678_9ABC_DEF0);
    run(4'h9, 0, 0, 0, 0, 64'h1234_5678_9ABC_DEF0, 64'd0);
    chk("R5 mod zero 32", r_res, 64'h0000_0000_9ABC_DEF0);
  endtask

  task automatic t_div;
    run(4'h3, 1, 1, 0, 0, 64'd100, 64'd7);
    chk("R7 udiv", r_res, 64'd14);
    chk("R7 div latency", 64'(r_cyc), 64'd65);
    run(4'h9, 1, 0, 0, 32'd7, 64'd100, 64'd0);
    chk("R7 umod", r_res, 64'd2);
    run(4'h3, 1, 0, 0, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    chk("R4 udiv by extended imm", r_res, 64'd1);
    run(4'h3, 0, 0, 0, 32'd3, 64'hFFFF_FFFF_0000_000A, 64'd0);
    chk("R3 udiv 32", r_res, 64'd3);
  endtask

  task automatic t_signed;
    run(4'h9, 1, 0, 16'd1, 32'd3, -64'sd13, 64'd0);
    chk("R6 smod -13,3", r_res, 64'hFFFF_FFFF_FFFF_FFFF);
    run(4'h3, 1, 0, 16'd1, 32'd3, -64'sd13, 64'd0);
    chk("R6 sdiv -13,3", r_res, 64'hFFFF_FFFF_FFFF_FFFC);
    run(4'h3, 0, 0, 16'd1, 32'd3, 64'h0000_0000_FFFF_FFF3, 64'd0);
    chk("R6 sdiv 32", r_res, 64'h0000_0000_FFFF_FFFC);
    run(4'h9, 1, 0, 16'd1, 32'hFFFF_FFFD, 64'd13, 64'd0);
    chk("R6 smod 13,-3", r_res, 64'd1);
  endtask

  task automatic t_shift;
    run(4'h6, 1, 1, 0, 0, 64'd1, 64'd65);
    chk("R8 lsh mask 63", r_res, 64'd2);
    run(4'h6, 0, 1, 0, 0, 64'd1, 64'd33);
    chk("R8 lsh mask 31", r_res, 64'd2);
    run(4'h7, 0, 0, 0, 32'd31, 64'hFFFF_FFFF_8000_0000, 64'd0);
    chk("R8 rsh 32", r_res, 64'd1);
    run(4'hc, 1, 0, 0, 32'd4, 64'h8000_0000_0000_0000, 64'd0);
    chk("R8 arsh 64", r_res, 64'hF800_0000_0000_0000);
    run(4'hc, 0, 0, 0, 32'd4, 64'h0000_0000_8000_0000, 64'd0);
    chk("R8 arsh 32", r_res, 64'h0000_0000_F800_0000);
  endtask

  task automatic t_neg;
    run(4'h8, 1, 0, 0, 0, 64'd5, 64'd0);
    chk("R9 neg 64", r_res, 64'hFFFF_FFFF_FFFF_FFFB);
    run(4'h8, 0, 0, 0, 0, 64'd5, 64'd0);
    chk("R9 neg 32", r_res, 64'h0000_0000_FFFF_FFFB);
  endtask

  task automatic t_movsx;
    run(4'hb, 1, 1, 16'd8, 0, 64'd0, 64'h80);
    chk("R10 sx8 64", r_res, 64'hFFFF_FFFF_FFFF_FF80);
    run(4'hb, 1, 1, 16'd16, 0, 64'd0, 64'hFFFF_7FFF);
    chk("R10 sx16 64", r_res, 64'h7FFF);
    run(4'hb, 1, 1, 16'd32, 0, 64'd0, 64'h1_8000_0000);
    chk("R10 sx32 64", r_res, 64'hFFFF_FFFF_8000_0000);
    run(4'hb, 0, 1, 16'd8, 0, 64'd0, 64'hFF);
    chk("R10 sx8 32", r_res, 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_end;
    logic [63:0] v = 64'h1122_3344_5566_7788;
    run(4'hd, 1, 0, 0, 32'd16, v, 64'd0);
    chk("R11 swap16", r_res, 64'h8877);
    run(4'hd, 1, 0, 0, 32'd32, v, 64'd0);
    chk("R11 swap32", r_res, 64'h8877_6655);
    run(4'hd, 1, 0, 0, 32'd64, v, 64'd0);
    chk("R11 swap64", r_res, 64'h8877_6655_4433_2211);
    run(4'hd, 0, 0, 0, 32'd16, v, 64'd0);
    chk("R12 to-le 16 pass", r_res, 64'h7788);
    run(4'hd, 0, 0, 0, 32'd64, v, 64'd0);
    chk("R12 to-le 64 pass", r_res, v);
    run(4'hd, 0, 1, 0, 32'd32, v, 64'd0);
    chk("R12 to-be 32 swap", r_res, 64'h8877_6655);
    run(4'hd, 0, 1, 0, 32'd64, v, 64'd0);
    chk("R12 to-be 64 swap", r_res, 64'h8877_6655_4433_2211);
  endtask

  task automatic ill_case(input string tag, input logic [3:0] o, input logic w,
                          input logic r, input logic [15:0] off, input logic [31:0] im);
    logic [63:0] d = 64'hDEAD_BEEF_0BAD_F00D;
    run(o, w, r, off, im, d, 64'd3);
    chk({"R13 flag ", tag}, {63'd0, r_ill}, 64'd1);
    chk({"R13 keep ", tag}, r_res, d);
  endtask

  task automatic t_illegal;
    ill_case("neg reg", 4'h8, 1, 1, 0, 0);
    ill_case("mov32 off32", 4'hb, 0, 1, 16'd32, 0);
    ill_case("mov off8 imm", 4'hb, 1, 0, 16'd8, 0);
    ill_case("mov off4", 4'hb, 1, 1, 16'd4, 0);
    ill_case("end width 24", 4'hd, 1, 0, 0, 32'd24);
    ill_case("end64 src bit", 4'hd, 1, 1, 0, 32'd16);
    ill_case("code e", 4'he, 1, 1, 0, 0);
    ill_case("add offset", 4'h0, 1, 1, 16'd1, 0);
    ill_case("div offset 2", 4'h3, 1, 1, 16'd2, 0);
  endtask

  task automatic t_busy_ignore;
    int n = 0;
    int dones = 0;
    @(negedge clk);
    op = 4'h3; wide = 1; use_reg = 1; offset = 0; dst_in = 64'd1000; src_in = 64'd10;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    op = 4'h0; dst_in = 64'd1; src_in = 64'd1; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk("R1 busy holds", {63'd0, busy}, 64'd1);
    chk("R1 no done on busy start", {63'd0, done}, 64'd0);
    while (n < 80) begin
      @(posedge clk); #1;
      n++;
      if (done) begin
        dones++;
        chk("R1 division result kept", result, 64'd100);
      end
    end
    chk("R1 single answer", 64'(dones), 64'd1);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_narrow;
    t_zero;
    t_div;
    t_signed;
    t_shift;
    t_neg;
    t_movsx;
    t_end;
    t_illegal;
    t_busy_ignore;
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule